// File: doc/BRIEF.md
# Reset and Exception Vector Controller

This block sits beside the fetch stage of a simple 32-bit processor. It holds the privileged status word and the exception program counter, and it tells fetch where to go next after a reset or an exception. Reset is handled as a special exception that never returns. Each clock edge seen with reset asserted loads the boot state and records the address of the instruction executing at that moment. The fetch redirect then points at the boot entry address.

An ordinary exception does three things on the edge where it is taken. It saves the faulting address, switches the core to kernel mode with interrupts off, and sends fetch to a vector. Which vector depends on the boot-vector status bit: while that bit is set, exceptions land in the uncached boot region; once software clears it, they land in the cached kernel segment.

Every redirect address is also given in physical form, with the kernel-segment prefix stripped. The redirect is a one-cycle valid pulse with no ready input. Fetch has no way to stall it and must act on it in the cycle it is valid. The status word is written through a plain enable/data pair, and the written value is in force for the next instruction.

Top module: `excvec_ctrl`

## Requirements
- R1: On every clock edge with `rst_n` low, the next cycle shows `redirect_valid`=1 and `redirect_vaddr`=0xBFC0_0000, for as long as reset is held.
- R2: The status word has bit 3 = boot-vector, bit 2 = exception level, bit 1 = user mode (0 = kernel) and bit 0 = interrupt enable. After a reset edge it reads 4'b1100.
- R3: On a reset edge, `epc` captures `cur_pc`. The value from the last edge before reset is released is the one kept.
- R4: `redirect_paddr` equals `redirect_vaddr` with the top three bits cleared when its top two bits are 2'b10, and equals it unchanged otherwise. `redirect_uncached` is 1 exactly when the top three bits are 3'b101. So 0xBFC0_0000 becomes 0x1FC0_0000.
- R5: An exception taken while the boot-vector bit is 1 gives `redirect_valid`=1 and `redirect_vaddr`=0xBFC0_0180 in the next cycle. This address lies inside the uncached boot region that starts at 0xBFC0_0100.
- R6: An exception taken while the boot-vector bit is 0 gives `redirect_vaddr`=0x8000_0080 in the next cycle, with physical address 0x0000_0080.
- R7: An exception has four effects in the next cycle: `epc` = `cur_pc` of the edge where it was taken, exception level = 1, user mode = 0, interrupt enable = 0, and the boot-vector bit unchanged.
- R8: In a cycle with no reset and no exception, `redirect_valid` is 0 in the next cycle. If `sr_wr_en` was 1 in that cycle, the status word equals `sr_wr_data` in the next cycle.
- R9: When reset and an exception are requested together, reset wins: the boot entry address, the reset status and the reset capture of `epc` all apply.
- R10: When an exception and a status write happen together, the exception wins and the write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as the reset exception |
| cur_pc | input | 32 | Address of the instruction executing in this cycle |
| exc_req | input | 1 | Take an exception on this edge |
| sr_wr_en | input | 1 | Write the status word |
| sr_wr_data | input | 4 | New status word value |
| status | output | 4 | Status word {boot-vector, exception level, user mode, interrupt enable} |
| epc | output | 32 | Exception program counter |
| redirect_valid | output | 1 | Fetch must jump to the redirect address in this cycle |
| redirect_vaddr | output | 32 | Redirect virtual address |
| redirect_paddr | output | 32 | Redirect physical address |
| redirect_uncached | output | 1 | Redirect address lies in the uncached kernel segment |

## Verification
Every result of this block is due exactly one cycle after the edge that sampled its cause. That covers the redirect pulse, the vector choice, the captured `epc` and a status write. The physical address follows the registered virtual address combinationally within that same cycle. For each stimulus cycle the driver computes the post-edge state from the requirements and queues it. The monitor pops one entry one nanosecond after each rising edge and compares it, so every entry is checked against the edge that consumed its inputs and against no other.

// File: rtl/excvec_pkg.sv
package excvec_pkg;
  parameter int unsigned ADDR_W = 32;

  typedef struct packed {
    logic bev;   // boot vectors in use
    logic exl;   // exception level
    logic um;    // user mode (0 = kernel)
    logic ie;    // interrupt enable
  } sts_t;

  localparam int unsigned STS_W = $bits(sts_t);

  function automatic sts_t sts_boot();
    sts_t s;
    s.bev = 1'b1;
    s.exl = 1'b1;
    s.um  = 1'b0;
    s.ie  = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/excvec_status.sv
module excvec_status
  import excvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_exc,
  input  logic             wr_en,
  input  logic [STS_W-1:0] wr_data,
  output sts_t             sts_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= sts_boot();
    end else if (take_exc) begin
      sts_q.exl <= 1'b1;
      sts_q.um  <= 1'b0;
      sts_q.ie  <= 1'b0;
    end else if (wr_en) begin
      sts_q <= sts_t'(wr_data);
    end
  end

  AST_STS_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sts_q == sts_boot())); // R2

  AST_EXC_ENTERS_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (sts_q.exl && !sts_q.um && !sts_q.ie && sts_q.bev == $past(sts_q.bev))); // R7

  AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take_exc) |=> (sts_q == sts_t'($past(wr_data)))); // R8

  AST_EXC_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && take_exc) |=> (sts_q.ie == 1'b0)); // R10
endmodule

// File: rtl/excvec_epc.sv
module excvec_epc
  import excvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_exc,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] epc_q
);
  // Reset is an exception too: the executing address is recorded on every reset edge.
  always_ff @(posedge clk) begin
    if (!rst_n || take_exc) begin
      epc_q <= pc;
    end
  end

  AST_EPC_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (epc_q == $past(pc))); // R3

  AST_EPC_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (epc_q == $past(pc))); // R7
endmodule

// File: rtl/excvec_vector.sv
module excvec_vector
  import excvec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_ENTRY = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hBFC0_0100,
  parameter logic [ADDR_W-1:0] NORM_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] GEN_OFFSET = 32'h0000_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_exc,
  input  logic              bev,
  output logic              redir_v,
  output logic [ADDR_W-1:0] redir_addr
);
  localparam logic [ADDR_W-1:0] BOOT_GEN = BOOT_BASE + GEN_OFFSET;
  localparam logic [ADDR_W-1:0] NORM_GEN = NORM_BASE + GEN_OFFSET;

  logic [ADDR_W-1:0] exc_target;
  assign exc_target = bev ? BOOT_GEN : NORM_GEN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_v    <= 1'b1;
      redir_addr <= BOOT_ENTRY;
    end else begin
      redir_v <= take_exc;
      if (take_exc) redir_addr <= exc_target;
    end
  end

  AST_BOOT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (redir_v && redir_addr == BOOT_ENTRY)); // R1

  AST_VECTOR_BY_BEV: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (redir_v && redir_addr == ($past(bev) ? BOOT_GEN : NORM_GEN))); // R5

  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |=> !redir_v); // R8
endmodule

// File: rtl/excvec_xlate.sv
module excvec_xlate
  import excvec_pkg::*;
#(
  parameter bit STRIP_CACHED = 1'b1
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] paddr,
  output logic              uncached
);
  localparam logic [ADDR_W-1:0] SEG_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  logic hit;
  assign uncached = (vaddr[ADDR_W-1 -: 3] == 3'b101);

  generate
    if (STRIP_CACHED) begin : g_both_segs
      assign hit = (vaddr[ADDR_W-1 -: 2] == 2'b10);
    end else begin : g_uncached_only
      assign hit = uncached;
    end
  endgenerate

  assign paddr = hit ? (vaddr & SEG_MASK) : vaddr;
endmodule

// File: rtl/excvec_ctrl.sv
module excvec_ctrl
  import excvec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cur_pc,
  input  logic        exc_req,
  input  logic        sr_wr_en,
  input  logic [3:0]  sr_wr_data,
  output logic [3:0]  status,
  output logic [31:0] epc,
  output logic        redirect_valid,
  output logic [31:0] redirect_vaddr,
  output logic [31:0] redirect_paddr,
  output logic        redirect_uncached
);
  sts_t sts;

  excvec_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_exc (exc_req),
    .wr_en    (sr_wr_en),
    .wr_data  (sr_wr_data),
    .sts_q    (sts)
  );

  excvec_epc u_epc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_exc (exc_req),
    .pc       (cur_pc),
    .epc_q    (epc)
  );

  excvec_vector u_vector (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_exc   (exc_req),
    .bev        (sts.bev),
    .redir_v    (redirect_valid),
    .redir_addr (redirect_vaddr)
  );

  excvec_xlate #(.STRIP_CACHED(1'b1)) u_xlate (
    .vaddr    (redirect_vaddr),
    .paddr    (redirect_paddr),
    .uncached (redirect_uncached)
  );

  assign status = sts;

  AST_REDIRECT_PHYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_paddr[31:29] == 3'b000)); // R4

  AST_BOOT_IS_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && status[3] && status[2]) |-> redirect_uncached); // R4
endmodule

// File: tb/sim_excvec_ctrl.sv
`timescale 1ns/100ps
module sim_excvec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        exc_req = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [3:0]  sr_wr_data = '0;
  logic [3:0]  status;
  logic [31:0] epc;
  logic        redirect_valid;
  logic [31:0] redirect_vaddr;
  logic [31:0] redirect_paddr;
  logic        redirect_uncached;

  always #2.5 clk = ~clk;

  excvec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_req(exc_req),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .status(status), .epc(epc),
    .redirect_valid(redirect_valid), .redirect_vaddr(redirect_vaddr),
    .redirect_paddr(redirect_paddr), .redirect_uncached(redirect_uncached)
  );

  typedef struct {
    logic        v;
    logic [31:0] va;
    logic [31:0] pa;
    logic        unc;
    logic [3:0]  st;
    logic [31:0] epc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic [3:0]  m_st  = 4'b1100;
  logic [31:0] m_va  = 32'hBFC0_0000;
  logic [31:0] m_epc = '0;

  task automatic step(input logic rst, input logic exc, input logic [31:0] pc,
                      input logic wr, input logic [3:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; exc_req = exc; cur_pc = pc; sr_wr_en = wr; sr_wr_data = wd;
    if (!rst) begin
      e.v = 1'b1; m_va = 32'hBFC0_0000; m_st = 4'b1100; m_epc = pc;
    end else if (exc) begin
      e.v = 1'b1;
      m_va = m_st[3] ? 32'hBFC0_0180 : 32'h8000_0080;
      m_epc = pc;
      m_st = {m_st[3], 3'b100};
    end else begin
      e.v = 1'b0;
      if (wr) m_st = wd;
    end
    e.va  = m_va;
    e.pa  = (m_va[31:30] == 2'b10) ? {3'b000, m_va[28:0]} : m_va;
    e.unc = (m_va[31:29] == 3'b101);
    e.st  = m_st;
    e.epc = m_epc;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one entry per rising edge, sampled 1 ns after it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (redirect_valid !== e.v || redirect_vaddr !== e.va || redirect_paddr !== e.pa ||
          redirect_uncached !== e.unc || status !== e.st || epc !== e.epc) begin
        fails++;
        $display("FAIL %s: got v=%0b va=%h pa=%h unc=%0b st=%b epc=%h exp v=%0b va=%h pa=%h unc=%0b st=%b epc=%h",
                 e.tag, redirect_valid, redirect_vaddr, redirect_paddr, redirect_uncached,
                 status, epc, e.v, e.va, e.pa, e.unc, e.st, e.epc);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1 R2 R3: reset held over several edges, epc follows the last one
    step(1'b0, 1'b0, 32'h0000_1000, 1'b0, 4'h0, "R1 R2 reset state");
    step(1'b0, 1'b0, 32'h0000_2004, 1'b0, 4'h0, "R3 reset epc");
    step(1'b0, 1'b0, 32'h8000_3008, 1'b1, 4'h3, "R4 boot paddr 1FC00000");
    // R8: idle and write-free cycles after release
    step(1'b1, 1'b0, 32'hBFC0_0000, 1'b0, 4'h0, "R8 no redirect when idle");
    // R5 R7: exception with boot vectors
    step(1'b1, 1'b1, 32'hBFC0_0044, 1'b0, 4'h0, "R5 boot exception vector");
    step(1'b1, 1'b0, 32'hBFC0_0180, 1'b0, 4'h0, "R7 state held after exception");
    // R8: status writes
    step(1'b1, 1'b0, 32'hBFC0_0184, 1'b1, 4'b0001, "R8 clear bev, enable interrupts");
    step(1'b1, 1'b0, 32'h0040_0000, 1'b1, 4'b0011, "R8 user mode with interrupts");
    // R6 R7: exception with normal vectors from user mode
    step(1'b1, 1'b1, 32'h0040_1234, 1'b0, 4'h0, "R6 R7 normal exception vector");
    step(1'b1, 1'b0, 32'h8000_0080, 1'b1, 4'b0001, "R8 write after exception");
    // R10: exception and write together
    step(1'b1, 1'b1, 32'h0040_2000, 1'b1, 4'b1011, "R10 exception beats write");
    step(1'b1, 1'b0, 32'h8000_0080, 1'b0, 4'h0, "R10 write discarded");
    // R9: reset and exception together
    step(1'b0, 1'b1, 32'h0040_3000, 1'b1, 4'b0001, "R9 reset beats exception");
    step(1'b1, 1'b1, 32'hBFC0_0010, 1'b0, 4'h0, "R5 exception right after reset");
    step(1'b1, 1'b0, 32'hBFC0_0180, 1'b1, 4'b0100, "R8 clear bev only");
    step(1'b1, 1'b1, 32'h8000_0200, 1'b0, 4'h0, "R6 exception from kernel");
    // mixed pattern from an LFSR
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1] | lfsr[2], lfsr[3] & lfsr[4], {lfsr, lfsr[7:0], 8'h5C},
           lfsr[5], lfsr[9:6], "R7 R8 R9 mixed traffic");
    end
    @(posedge clk); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule